// File: doc/BRIEF.md
# Read Response Data-Phase Controller

This block sits on the target side of a graphics port and returns read data to the graphics master. The master queues read requests, each carrying a priority bit and a byte length. The block keeps one in-order queue of pending lengths per priority. When the bus can take a new response, it grants it. On the grant clock it drives a 3-bit status code that names the priority, and from the next clock it runs the data phase, one bus word per clock.

A data phase is cut into blocks of four clocks. The first block of a response always flows without any acknowledgement. When a block has a successor, the master's initiator-ready and the block's own target-ready are sampled from the block's third clock onward. The next block starts two clocks after the first clock on which both are high, and the clocks in between that carry no data are wait states.

Read data comes from a simple valid/ready source. In a wait state, target-ready follows that source's valid. A read-buffer-full input from the master holds back new low-priority grants, while high-priority grants and any response already under way carry on.

Top module: `rd_resp_phase_ctrl`

## Requirements
- R1: During and straight after reset: `gnt` and `trdy` are 0, `dat_valid` is 0, and `st` is 3'b111.
- R2: `gnt` is high for exactly one clock per scheduled response. On that clock `st` is {2'b00, p}, where p=1 means high priority. On every other clock `st` is 3'b111, and a write code (3'b01x) is never issued.
- R3: The first data clock is the clock directly after the grant. On every data clock `trdy` is 1 and `be` is all ones. On clocks that carry no data, `be` is all zeros.
- R4: Within each priority, responses are served oldest first. At a grant, a non-empty high-priority queue always wins. `rsp_hi` gives the priority of the response on the bus. Each queue holds QDEPTH lengths.
- R5: A request of N bytes (1..MAX_BYTES) gives ceil(N / (DATA_W/8)) data clocks. `rsp_last` is high on the final data clock only.
- R6: The four data clocks of a block run back to back, whatever `irdy` does.
- R7: If `irdy` is high on the third clock of a block that has a successor, the next block starts on the clock right after the block's fourth clock, with no wait state.
- R8: Otherwise, the clocks after the block's fourth clock are wait states. In a wait state `trdy` equals `src_valid`. The next block starts two clocks after the first clock, from the third clock of the block onward, on which `irdy` and `trdy` are both high.
- R9: While `rbf` is high, no low-priority grant is issued. High-priority grants are still issued, and a response already granted completes in full.
- R10: A grant is issued only while the bus is idle or on the final data clock of the current response, so that consecutive responses follow with no idle clock.
- R11: `src_ready` is high exactly on data clocks, and `dat` equals `src_data` then. The source must hold `src_valid` high whenever `src_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Queue a read request this clock |
| req_hi | input | 1 | Priority of the request (1 = high) |
| req_bytes | input | 9 | Request length in bytes, 1..MAX_BYTES |
| irdy | input | 1 | Master ready to continue (handshake) |
| rbf | input | 1 | Master read buffer full |
| src_valid | input | 1 | Data source has a word |
| src_data | input | 64 | Data source word |
| src_ready | output | 1 | Word taken from the source this clock |
| gnt | output | 1 | Bus granted for a read response |
| st | output | 3 | Status code for the grant |
| trdy | output | 1 | Target ready |
| dat_valid | output | 1 | A data word is on `dat` |
| dat | output | 64 | Read data word |
| be | output | 8 | Byte enables, active high |
| rsp_last | output | 1 | Final data clock of the response |
| rsp_hi | output | 1 | Priority of the response on the bus |

## Verification
The assertions assume three things about the inputs. Requests never push into a full queue unless a grant frees a slot on the same clock. `req_bytes` lies between 1 and MAX_BYTES. The source offers a word on every data clock. The bench's model tracks queue occupancy and only raises `req_valid` when the chosen queue has room. It draws lengths from the legal range. It holds `src_valid` high on every clock the model predicts as a data clock, and randomises `src_valid` only on wait states, where it decides target readiness.

// File: rtl/rdrsp_pkg.sv
`timescale 1ns/1ps
package rdrsp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;

  // status code driven when no read grant is on the bus
  localparam logic [2:0] ST_NONE = 3'b111;

  // clocks needed to move nbytes over a bus of bus_bytes per clock
  function automatic int unsigned bytes_to_clocks(input int unsigned nbytes,
                                                  input int unsigned bus_bytes);
    return (nbytes + bus_bytes - 1) / bus_bytes;
  endfunction

endpackage

// File: rtl/rdrsp_lenq.sv
`timescale 1ns/1ps
module rdrsp_lenq #(
  parameter int W     = 6,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);  // R4

endmodule

// File: rtl/rdrsp_pick.sv
`timescale 1ns/1ps
module rdrsp_pick (
  input  logic can_load,
  input  logic hi_pending,
  input  logic lo_pending,
  input  logic rbf,
  output logic gnt,
  output logic sel_hi
);
  // high priority always wins; low priority is held back by a full buffer
  assign sel_hi = hi_pending;
  assign gnt    = can_load && (hi_pending || (lo_pending && !rbf));
endmodule

// File: rtl/rdrsp_beat_eng.sv
`timescale 1ns/1ps
module rdrsp_beat_eng #(
  parameter int CLK_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CLK_W-1:0] load_len,
  input  logic             irdy,
  input  logic             src_valid,
  output logic             beat,
  output logic             last_beat,
  output logic             can_load,
  output logic             trdy
);
  import rdrsp_pkg::*;

  phase_t           phase_q, phase_d;
  logic [1:0]       pos_q, pos_d;     // clock index inside the block
  logic [CLK_W-1:0] rem_q, rem_d;     // data clocks left, current included
  logic             hs_q, hs_d;       // handshake met on third clock
  logic             arm_q, arm_d;     // handshake met during wait states
  logic             both;

  assign beat      = (phase_q == PH_DATA);
  assign last_beat = beat && (rem_q == CLK_W'(1));
  assign can_load  = (phase_q == PH_IDLE) || last_beat;
  assign trdy      = beat || ((phase_q == PH_WAIT) && src_valid);
  assign both      = irdy && trdy;

  always_comb begin
    phase_d = phase_q;
    pos_d   = pos_q;
    rem_d   = rem_q;
    hs_d    = hs_q;
    arm_d   = arm_q;
    if (load) begin
      phase_d = PH_DATA;
      pos_d   = 2'd0;
      rem_d   = load_len;
      hs_d    = 1'b0;
      arm_d   = 1'b0;
    end else begin
      unique case (phase_q)
        PH_DATA: begin
          if (last_beat) begin
            phase_d = PH_IDLE;
          end else begin
            rem_d = rem_q - CLK_W'(1);
            if (pos_q == 2'd3) begin
              pos_d = 2'd0;
              if (hs_q) begin
                hs_d = 1'b0;
              end else begin
                phase_d = PH_WAIT;
                arm_d   = both;
              end
            end else begin
              pos_d = pos_q + 2'd1;
              if (pos_q == 2'd2 && both) hs_d = 1'b1;
            end
          end
        end
        PH_WAIT: begin
          if (arm_q) begin
            phase_d = PH_DATA;
            arm_d   = 1'b0;
            hs_d    = 1'b0;
          end else if (both) begin
            arm_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pos_q   <= 2'd0;
      rem_q   <= '0;
      hs_q    <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pos_q   <= pos_d;
      rem_q   <= rem_d;
      hs_q    <= hs_d;
      arm_q   <= arm_d;
    end
  end

  AST_FIRST_BLOCK_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && pos_q != 2'd3 && !last_beat) |=> beat);  // R6
  AST_THIRD_CLOCK_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && pos_q == 2'd2 && rem_q > CLK_W'(2) && irdy) |=> ##1 (beat && pos_q == 2'd0));  // R7
  AST_WAIT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && !arm_q && both) |=> ##1 (beat && pos_q == 2'd0));  // R8
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && !arm_q && !both) |=> !beat);  // R8

endmodule

// File: rtl/rd_resp_phase_ctrl.sv
`timescale 1ns/1ps
module rd_resp_phase_ctrl #(
  parameter int DATA_W    = 64,
  parameter int MAX_BYTES = 256,
  parameter int QDEPTH    = 4,
  localparam int BUS_BYTES = DATA_W / 8,
  localparam int BYTE_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_hi,
  input  logic [BYTE_W-1:0]    req_bytes,
  input  logic                 irdy,
  input  logic                 rbf,
  input  logic                 src_valid,
  input  logic [DATA_W-1:0]    src_data,
  output logic                 src_ready,
  output logic                 gnt,
  output logic [2:0]           st,
  output logic                 trdy,
  output logic                 dat_valid,
  output logic [DATA_W-1:0]    dat,
  output logic [BUS_BYTES-1:0] be,
  output logic                 rsp_last,
  output logic                 rsp_hi
);
  import rdrsp_pkg::*;

  localparam int CLK_W = $clog2(MAX_BYTES / BUS_BYTES + 2);

  logic [CLK_W-1:0] req_clocks;
  logic [1:0]       q_push, q_pop, q_empty, q_full;
  logic [CLK_W-1:0] q_head [2];
  logic             sel_hi, can_load, beat, last_beat;
  logic [CLK_W-1:0] load_len;
  logic             rsp_hi_q;

  assign req_clocks = CLK_W'(bytes_to_clocks(32'(req_bytes), BUS_BYTES));

  for (genvar q = 0; q < 2; q++) begin : g_queue
    assign q_push[q] = req_valid && (req_hi == 1'(q));
    assign q_pop[q]  = gnt && (sel_hi == 1'(q));
    rdrsp_lenq #(.W(CLK_W), .DEPTH(QDEPTH)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[q]),
      .din   (req_clocks),
      .pop   (q_pop[q]),
      .dout  (q_head[q]),
      .empty (q_empty[q]),
      .full  (q_full[q])
    );
  end

  rdrsp_pick u_pick (
    .can_load   (can_load),
    .hi_pending (!q_empty[1]),
    .lo_pending (!q_empty[0]),
    .rbf        (rbf),
    .gnt        (gnt),
    .sel_hi     (sel_hi)
  );

  assign load_len = sel_hi ? q_head[1] : q_head[0];

  rdrsp_beat_eng #(.CLK_W(CLK_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (gnt),
    .load_len  (load_len),
    .irdy      (irdy),
    .src_valid (src_valid),
    .beat      (beat),
    .last_beat (last_beat),
    .can_load  (can_load),
    .trdy      (trdy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rsp_hi_q <= 1'b0;
    else if (gnt) rsp_hi_q <= sel_hi;
  end

  assign st        = gnt ? {2'b00, sel_hi} : ST_NONE;
  assign dat_valid = beat;
  assign rsp_last  = last_beat;
  assign rsp_hi    = rsp_hi_q;
  assign src_ready = beat;
  assign dat       = src_data;
  assign be        = {BUS_BYTES{beat}};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && q_full[req_hi]) |-> (gnt && sel_hi == req_hi));  // R4
  AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && !q_empty[1]) |-> st == 3'b001);  // R4
  AST_GRANT_OPENS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |=> (dat_valid && trdy));  // R3
  AST_RBF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && rbf) |-> st == 3'b001);  // R9
  AST_GRANT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> (!dat_valid || rsp_last));  // R10
  AST_SRC_FED: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> src_valid);  // R11

endmodule

// File: tb/sim_rd_resp_phase_ctrl.sv
`timescale 1ns/1ps
module sim_rd_resp_phase_ctrl;
  localparam int DW   = 64;
  localparam int MAXB = 256;
  localparam int QD   = 4;
  localparam int BB   = DW / 8;
  localparam int BW   = $clog2(MAXB + 1);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_hi = 1'b0;
  logic [BW-1:0] req_bytes = '0;
  logic          irdy = 1'b0, rbf = 1'b0, src_valid = 1'b0;
  logic [DW-1:0] src_data;
  logic          src_ready, gnt, trdy, dat_valid, rsp_last, rsp_hi;
  logic [2:0]    st;
  logic [DW-1:0] dat;
  logic [BB-1:0] be;

  always #10 clk = ~clk;

  rd_resp_phase_ctrl #(.DATA_W(DW), .MAX_BYTES(MAXB), .QDEPTH(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hi(req_hi),
    .req_bytes(req_bytes), .irdy(irdy), .rbf(rbf), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .gnt(gnt), .st(st),
    .trdy(trdy), .dat_valid(dat_valid), .dat(dat), .be(be),
    .rsp_last(rsp_last), .rsp_hi(rsp_hi));

  int n_tests = 0, n_fail = 0;
  int p_req = 0, p_hi = 0, p_irdy = 100, p_rbf = 0, p_src = 100, len_mode = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] src_word(input int n);
    return {2{32'(n) ^ 32'h5A5A_0000}};
  endfunction

  // source
  int dcnt = 0;
  assign src_data = src_word(dcnt);
  always @(posedge clk) if (rst_n && src_valid && src_ready) dcnt++;

  // behavioural reference
  int m_hiq[$], m_loq[$];
  int m_left = 0, m_inblk = 0, m_ok = -1, m_resume = 0, m_cyc = 0, m_beats = 0;
  bit m_hi = 0;
  bit e_beat, e_trdy, e_gnt, e_sel, e_last;

  function automatic void model_eval();
    e_beat = (m_left > 0) && (m_inblk < 4 || (m_ok >= 0 && m_cyc == m_resume));
    e_trdy = e_beat || (m_left > 0 && src_valid);
    e_last = e_beat && (m_left == 1);
    e_sel  = (m_hiq.size() > 0);
    e_gnt  = (m_left == 0 || e_last) && (m_hiq.size() > 0 || (m_loq.size() > 0 && !rbf));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hiq.delete(); m_loq.delete();
      m_left = 0; m_inblk = 0; m_ok = -1; m_cyc = 0; m_beats = 0; m_hi = 0;
    end else begin
      model_eval();
      if (e_beat && m_inblk == 4) begin m_inblk = 0; m_ok = -1; end
      if (m_left > 0 && m_ok < 0 && irdy && e_trdy &&
          (!e_beat || m_inblk >= 2) && m_left > 4 - m_inblk) begin
        m_ok = m_cyc; m_resume = m_cyc + 2;
      end
      if (e_beat) begin m_inblk++; m_left--; m_beats++; end
      if (e_gnt) begin
        m_left = e_sel ? m_hiq.pop_front() : m_loq.pop_front();
        m_inblk = 0; m_ok = -1; m_hi = e_sel;
      end
      if (req_valid) begin
        if (req_hi) m_hiq.push_back((int'(req_bytes) + BB - 1) / BB);
        else        m_loq.push_back((int'(req_bytes) + BB - 1) / BB);
      end
      m_cyc++;
    end
  end

  // stimulus, driven after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      bit hi;
      int room;
      rbf  = ($urandom_range(99) < p_rbf);
      irdy = ($urandom_range(99) < p_irdy);
      hi   = ($urandom_range(99) < p_hi);
      room = hi ? QD - m_hiq.size() : QD - m_loq.size();
      req_valid = ($urandom_range(99) < p_req) && room > 0;
      req_hi    = hi;
      case (len_mode)
        1:       req_bytes = BW'($urandom_range(1, 16));
        2:       req_bytes = BW'($urandom_range(MAXB - 7, MAXB));
        default: req_bytes = BW'($urandom_range(1, MAXB));
      endcase
      model_eval();
      src_valid = e_beat ? 1'b1 : ($urandom_range(99) < p_src);
    end
  end

  // per-clock comparison and port-level counters
  int ov_grants = 0, gaps = 0, lo_rbf = 0, hi_rbf = 0;
  bit busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      model_eval();
      chk("R2 gnt", gnt, e_gnt);
      chk("R2/R4 st", st, e_gnt ? {2'b00, e_sel} : 3'b111);
      chk("R6/R7 dat_valid", dat_valid, e_beat);
      chk("R8 trdy", trdy, e_trdy);
      chk("R5 rsp_last", rsp_last, e_last);
      chk("R3 be", be, e_beat ? {BB{1'b1}} : '0);
      chk("R11 src_ready", src_ready, e_beat);
      if (e_beat) begin
        chk("R11 dat", dat, src_word(m_beats));
        chk("R4 rsp_hi", rsp_hi, m_hi);
      end
      if (gnt && dat_valid) ov_grants++;
      if (busy && !dat_valid) gaps++;
      if (gnt && rbf && st == 3'b000) lo_rbf++;
      if (gnt && rbf && st == 3'b001) hi_rbf++;
      if (dat_valid) busy = !rsp_last;
    end
  end

  task automatic run(input int pr, input int ph, input int pi, input int pb,
                     input int ps, input int lm, input int n);
    p_req = pr; p_hi = ph; p_irdy = pi; p_rbf = pb; p_src = ps; len_mode = lm;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gnt", gnt, 0);
    chk("R1 st", st, 3'b111);
    chk("R1 trdy", trdy, 0);
    chk("R1 dat_valid", dat_valid, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 st after reset", st, 3'b111);
    chk("R1 dat_valid after reset", dat_valid, 0);

    ov_grants = 0;
    run(60, 50, 100, 0, 100, 1, 2000);
    chk("R10 overlapped grants seen", ov_grants > 0, 1);

    run(0, 0, 100, 0, 100, 0, 300);
    gaps = 0;
    run(25, 50, 100, 0, 100, 2, 2000);
    chk("R7 no wait states with irdy held", gaps, 0);

    gaps = 0;
    run(40, 40, 50, 0, 60, 0, 4000);
    chk("R8 wait states seen", gaps > 0, 1);
    run(40, 40, 60, 30, 60, 0, 4000);

    lo_rbf = 0; hi_rbf = 0;
    run(40, 0, 80, 100, 70, 0, 400);
    run(40, 40, 80, 100, 70, 0, 600);
    chk("R9 no low grant under rbf", lo_rbf, 0);
    chk("R9 high grant under rbf", hi_rbf > 0, 1);

    run(0, 0, 100, 0, 100, 0, 400);
    chk("R5 all responses drained", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule